// File: doc/BRIEF.md
# Zero-Count Execution Unit

This unit sits in the execute stage of a 64-bit integer pipeline and handles the four zero-count instructions of the bit-manipulation extension. It takes a 32-bit instruction word together with the already-read first source operand and recognises the instruction itself. It then counts the leading or trailing zero bits of either the whole 64-bit operand or only its lower 32 bits. The count is returned as a zero-extended 64-bit value, together with the destination register index taken from the instruction.

Two control inputs decide legality. One says the bit-manipulation extension is enabled. The other says the core runs in 64-bit mode, which the 32-bit word forms need. A recognised but forbidden instruction is reported on an illegal flag only. Trap delivery, register-file access and hazards belong to the surrounding pipeline. All outputs are registered and appear one clock after the input strobe.

Top module: `zc_unit`

## Requirements
- R1: An instruction with bits [31:20] = 0x600, bits [14:12] = 001 and bits [6:0] = 0010011 yields the number of leading zero bits of the 64-bit operand. An all-zero operand yields 64.
- R2: An instruction with bits [31:20] = 0x601, bits [14:12] = 001 and bits [6:0] = 0010011 yields the number of trailing zero bits of the 64-bit operand. An all-zero operand yields 64.
- R3: An instruction with bits [31:25] = 0110000, bits [24:20] = 00000, bits [14:12] = 001 and bits [6:0] = 0011011 yields the number of leading zero bits of operand bits [31:0] seen as a 32-bit value. The result is in 0..32 and operand bits [63:32] have no effect.
- R4: An instruction with bits [31:25] = 0110000, bits [24:20] = 00001, bits [14:12] = 001 and bits [6:0] = 0011011 yields the number of trailing zero bits of operand bits [31:0]. Zero in those bits yields 32, and operand bits [63:32] have no effect.
- R5: When ext_en is low, any of the four encodings gives out_illegal = 1, out_valid = 0 and out_result = 0. out_valid and out_illegal are never high together.
- R6: When mode64 is low, the two word forms (R3, R4) give out_illegal = 1, out_valid = 0 and out_result = 0. The full-width forms still complete normally.
- R7: An instruction word that matches none of the four encodings gives out_valid = 0, out_illegal = 0, out_rd = 0 and out_result = 0.
- R8: For any of the four encodings, out_rd equals instruction bits [11:7]. The bits [19:15] (source index field) do not change any output.
- R9: Outputs are registered. They reflect the inputs sampled at the rising edge where in_valid is high. After an edge with in_valid low, out_valid, out_illegal, out_rd and out_result are all 0.
- R10: A synchronous active-high rst clears out_valid, out_illegal, out_rd and out_result at the next rising edge.
- R11: out_result bits [63:7] are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe: instruction and operand are present this cycle |
| instr | input | 32 | Instruction word |
| src | input | 64 | First source operand value |
| ext_en | input | 1 | Bit-manipulation extension enabled |
| mode64 | input | 1 | Core runs in 64-bit mode |
| out_valid | output | 1 | Legal zero-count instruction completed |
| out_illegal | output | 1 | Recognised zero-count instruction that is not allowed |
| out_rd | output | 5 | Destination register index |
| out_result | output | 64 | Zero-extended count |

## Verification
Every output is due exactly one rising edge after the edge that samples the strobe, so the bench drives inputs on the falling edge and compares all four outputs one nanosecond after the next rising edge. It compares them with values its own counting functions derive from the requirement encodings. Idle cycles and the reset are checked in the same way, one edge after they are applied, so a design that adds or drops a pipeline stage will mismatch on the first check.

// File: rtl/zc_pkg.sv
package zc_pkg;

    localparam int XLEN   = 64;
    localparam int WLEN   = 32;
    localparam int CNT_W  = $clog2(XLEN + 1);

    localparam logic [6:0]  OPC_IMM      = 7'b0010011;
    localparam logic [6:0]  OPC_IMM_32   = 7'b0011011;
    localparam logic [2:0]  F3_COUNT     = 3'b001;
    localparam logic [11:0] HI_FULL_LEAD = 12'h600;
    localparam logic [11:0] HI_FULL_TRL  = 12'h601;
    localparam logic [6:0]  HI_WORD_TOP  = 7'b0110000;
    localparam logic [4:0]  SEL_LEAD     = 5'd0;
    localparam logic [4:0]  SEL_TRAIL    = 5'd1;

    typedef enum logic [2:0] {
        ZC_NONE,
        ZC_LEAD,
        ZC_TRAIL,
        ZC_LEAD_W,
        ZC_TRAIL_W
    } zc_op_e;

    typedef struct packed {
        zc_op_e     op;
        logic       word_form;
        logic [4:0] rd;
    } zc_dec_t;

    typedef struct packed {
        logic            valid;
        logic            illegal;
        logic [4:0]      rd;
        logic [XLEN-1:0] result;
    } zc_out_t;

    function automatic logic [XLEN-1:0] bit_reverse(input logic [XLEN-1:0] v);
        logic [XLEN-1:0] r;
        for (int i = 0; i < XLEN; i++) r[i] = v[XLEN-1-i];
        return r;
    endfunction

endpackage

// File: rtl/zc_decode.sv
module zc_decode
    import zc_pkg::*;
(
    input  logic [31:0] instr,
    output zc_dec_t     dec
);
    logic is_cnt_imm;
    logic is_cnt_imm32;

    always_comb begin
        is_cnt_imm   = (instr[6:0] == OPC_IMM)    && (instr[14:12] == F3_COUNT);
        is_cnt_imm32 = (instr[6:0] == OPC_IMM_32) && (instr[14:12] == F3_COUNT)
                       && (instr[31:25] == HI_WORD_TOP);
        dec.op = ZC_NONE;
        if (is_cnt_imm && instr[31:20] == HI_FULL_LEAD)
            dec.op = ZC_LEAD;
        else if (is_cnt_imm && instr[31:20] == HI_FULL_TRL)
            dec.op = ZC_TRAIL;
        else if (is_cnt_imm32 && instr[24:20] == SEL_LEAD)
            dec.op = ZC_LEAD_W;
        else if (is_cnt_imm32 && instr[24:20] == SEL_TRAIL)
            dec.op = ZC_TRAIL_W;
        dec.word_form = (dec.op == ZC_LEAD_W) || (dec.op == ZC_TRAIL_W);
        dec.rd        = (dec.op == ZC_NONE) ? 5'd0 : instr[11:7];
    end
endmodule

// File: rtl/zc_prep.sv
module zc_prep
    import zc_pkg::*;
(
    input  zc_op_e          op,
    input  logic [XLEN-1:0] src,
    output logic [XLEN-1:0] scan
);
    logic [XLEN-1:0] shaped;

    always_comb begin
        unique case (op)
            ZC_LEAD_W:  shaped = {{(XLEN-WLEN){1'b0}}, src[WLEN-1:0]};
            ZC_TRAIL_W: shaped = {{(XLEN-WLEN){1'b1}}, src[WLEN-1:0]};
            default:    shaped = src;
        endcase
        if (op == ZC_TRAIL || op == ZC_TRAIL_W)
            scan = bit_reverse(shaped);
        else
            scan = shaped;
    end
endmodule

// File: rtl/zc_lzc.sv
module zc_lzc #(
    parameter int W = 64,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);
    logic hit;

    always_comb begin
        hit = 1'b0;
        cnt = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (!hit && vec[W-1-i]) begin
                hit = 1'b1;
                cnt = CW'(i);
            end
        end
    end
endmodule

// File: rtl/zc_unit.sv
module zc_unit
    import zc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [31:0]     instr,
    input  logic [63:0]     src,
    input  logic            ext_en,
    input  logic            mode64,
    output logic            out_valid,
    output logic            out_illegal,
    output logic [4:0]      out_rd,
    output logic [63:0]     out_result
);
    zc_dec_t          dec;
    logic [XLEN-1:0]  scan;
    logic [CNT_W-1:0] raw_cnt;
    logic [CNT_W-1:0] adj_cnt;
    logic             matched;
    logic             allowed;
    zc_out_t          nxt;
    zc_out_t          q;

    zc_decode u_dec  (.instr(instr), .dec(dec));
    zc_prep   u_prep (.op(dec.op), .src(src), .scan(scan));
    zc_lzc #(.W(XLEN)) u_cnt (.vec(scan), .cnt(raw_cnt));

    always_comb begin
        adj_cnt = (dec.op == ZC_LEAD_W) ? raw_cnt - CNT_W'(XLEN - WLEN) : raw_cnt;
        matched = in_valid && (dec.op != ZC_NONE);
        allowed = ext_en && (!dec.word_form || mode64);
        nxt.valid   = matched && allowed;
        nxt.illegal = matched && !allowed;
        nxt.rd      = matched ? dec.rd : 5'd0;
        nxt.result  = (matched && allowed) ? {{(XLEN-CNT_W){1'b0}}, adj_cnt} : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

    assign out_valid   = q.valid;
    assign out_illegal = q.illegal;
    assign out_rd      = q.rd;
    assign out_result  = q.result;

    assert_excl_R5: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && out_illegal));
    assert_ext_off_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !ext_en) |=> (!out_valid && out_result == '0));
    assert_mode32_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !mode64 && dec.word_form) |=> !out_valid);
    assert_word_range_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && dec.op == ZC_LEAD_W && ext_en && mode64) |=> (out_result <= 64'd32));
    assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !out_illegal && out_rd == '0 && out_result == '0));
    assert_reset_R10: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_illegal && out_rd == '0 && out_result == '0));
    assert_zext_R11: assert property (@(posedge clk) disable iff (rst)
        out_result[63:7] == '0);
endmodule

// File: tb/zc_unit_test.sv
module zc_unit_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] instr;
    logic [63:0] src;
    logic        ext_en;
    logic        mode64;
    logic        out_valid;
    logic        out_illegal;
    logic [4:0]  out_rd;
    logic [63:0] out_result;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    zc_unit uut (.*);

    always #2 clk = ~clk;

    function automatic logic [31:0] mk(int kind, logic [4:0] rd, logic [4:0] rs);
        case (kind)
            0: return {12'h600, rs, 3'b001, rd, 7'b0010011};
            1: return {12'h601, rs, 3'b001, rd, 7'b0010011};
            2: return {7'b0110000, 5'b00000, rs, 3'b001, rd, 7'b0011011};
            3: return {7'b0110000, 5'b00001, rs, 3'b001, rd, 7'b0011011};
            default: return 32'h0000_0033;
        endcase
    endfunction

    function automatic int kind_of(logic [31:0] w);
        for (int k = 0; k < 4; k++)
            if (w == mk(k, w[11:7], w[19:15])) return k;
        return 4;
    endfunction

    function automatic int lead64(logic [63:0] v);
        for (int i = 63; i >= 0; i--) if (v[i]) return 63 - i;
        return 64;
    endfunction

    function automatic int trail64(logic [63:0] v);
        for (int i = 0; i < 64; i++) if (v[i]) return i;
        return 64;
    endfunction

    function automatic string tag(int k);
        case (k)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            default: return "R7";
        endcase
    endfunction

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step(logic [31:0] w, logic [63:0] s, logic en, logic m64, logic v);
        int k;
        logic legal;
        logic [63:0] exp_res;
        string req;
        @(negedge clk);
        in_valid = v; instr = w; src = s; ext_en = en; mode64 = m64;
        @(posedge clk); #1;
        k = kind_of(w);
        req = v ? tag(k) : "R9";
        legal = en && (k < 2 || m64);
        if (v && k < 4 && !en) req = "R5";
        else if (v && k >= 2 && k < 4 && !m64) req = "R6";
        case (k)
            0: exp_res = 64'(lead64(s));
            1: exp_res = 64'(trail64(s));
            2: exp_res = 64'(lead64({32'h0, s[31:0]}) - 32);
            3: exp_res = 64'(trail64({32'hFFFF_FFFF, s[31:0]}));
            default: exp_res = '0;
        endcase
        if (!(v && k < 4 && legal)) exp_res = '0;
        check(req, "valid",   64'(out_valid),   64'(v && k < 4 && legal));
        check(req, "illegal", 64'(out_illegal), 64'(v && k < 4 && !legal));
        check((v && k < 4) ? "R8" : req, "rd", 64'(out_rd), (v && k < 4) ? 64'(w[11:7]) : 64'd0);
        check(req, "result",  out_result, exp_res);
        check("R11", "upper result bits", 64'(out_result[63:7]), 64'd0);
    endtask

    initial begin
        logic [63:0] opnd;
        int junk;
        junk = $urandom(32'd2024);
        rst = 1'b1; in_valid = 0; instr = '0; src = '0; ext_en = 1; mode64 = 1;
        @(negedge clk); @(negedge clk);
        check("R10", "valid after reset", 64'(out_valid), 0);
        check("R10", "result after reset", out_result, 0);
        rst = 1'b0;

        // R1 / R2 full-width corners
        step(mk(0, 5'd3, 5'd9), 64'h0, 1, 1, 1);
        step(mk(0, 5'd4, 5'd0), '1, 1, 1, 1);
        step(mk(0, 5'd5, 5'd1), 64'h1, 1, 1, 1);
        step(mk(1, 5'd6, 5'd2), 64'h0, 1, 1, 1);
        step(mk(1, 5'd7, 5'd3), 64'h8000_0000_0000_0000, 1, 1, 1);
        step(mk(1, 5'd8, 5'd31), '1, 1, 1, 1);
        // R3 / R4 word corners, upper bits must not matter
        step(mk(2, 5'd9, 5'd4), 64'hFFFF_FFFF_0000_0000, 1, 1, 1);
        step(mk(2, 5'd10, 5'd5), 64'hFFFF_FFFF_0000_0001, 1, 1, 1);
        step(mk(2, 5'd11, 5'd6), 64'h0000_0000_8000_0000, 1, 1, 1);
        step(mk(3, 5'd12, 5'd7), 64'h0, 1, 1, 1);
        step(mk(3, 5'd13, 5'd8), 64'h0000_0001_8000_0000, 1, 1, 1);
        step(mk(3, 5'd14, 5'd8), 64'h0000_0001_0000_0000, 1, 1, 1);
        // R5 / R6 legality
        step(mk(0, 5'd15, 5'd1), 64'h10, 0, 1, 1);
        step(mk(3, 5'd16, 5'd1), 64'h10, 0, 1, 1);
        step(mk(2, 5'd17, 5'd1), 64'h10, 1, 0, 1);
        step(mk(1, 5'd18, 5'd1), 64'h10, 1, 0, 1);
        // R7 unmatched, R9 idle
        step(32'h6020_9013, 64'h10, 1, 1, 1);
        step(mk(0, 5'd19, 5'd1) ^ 32'h0000_4000, 64'h10, 1, 1, 1);
        step(mk(0, 5'd20, 5'd1), 64'h10, 1, 1, 0);

        for (int n = 0; n < 600; n++) begin
            int k;
            logic [31:0] w;
            k = int'($urandom % 5);
            w = (k == 4) ? $urandom : mk(k, 5'($urandom), 5'($urandom));
            case ($urandom % 5)
                0: opnd = '0;
                1: opnd = '1;
                2: opnd = 64'h1 << ($urandom % 64);
                default: opnd = {$urandom, $urandom} >> ($urandom % 64);
            endcase
            step(w, opnd, ($urandom % 8) != 0, ($urandom % 4) != 0, ($urandom % 10) != 0);
        end

        // R10 mid-run reset
        @(negedge clk);
        in_valid = 1; instr = mk(0, 5'd21, 5'd0); src = 64'h0; ext_en = 1; mode64 = 1;
        @(posedge clk); #1;
        check("R1", "valid before reset", 64'(out_valid), 1);
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        check("R10", "valid during reset", 64'(out_valid), 0);
        check("R10", "rd during reset", 64'(out_rd), 0);
        check("R10", "result during reset", out_result, 0);
        rst = 1'b0;

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule